// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one counting channel of a classic programmable interval timer. It includes the decoder for that channel's control word. Software writes a control byte to set the channel up or to take a snapshot of its count. It then loads a 16-bit start value through a byte-wide data port, low byte first. The count moves down by one on each cycle where `tick_en` is high. A system-level divider drives that strobe at the 1193180 Hz timer rate.

Three operating modes are built. In terminal-count mode the output rises once when the count runs out. The rate generator gives one low tick per period. The square-wave mode spends half of each period high and half low. The count can be read back live, or frozen by a latch command and read back later. Control words this channel cannot honour raise a one-cycle error pulse and are otherwise dropped.

Top module: `pit_channel`

## Requirements
- R1: The control byte is split into select = bits [7:6], access = bits [5:4], mode = bits [3:1] and bcd = bit [0]. A word whose select is neither 3 nor the channel's own number (parameter CHAN_SEL, default 0) has no effect on this channel and raises no error.
- R2: `cfg_err` is high for exactly the cycle after a control write that has any of these: select = 3, access = 01 or 10, bcd = 1 with access = 11, or a mode other than 0, 2 or 3 with access = 11. Such a word changes no count, mode, pointer or output.
- R3: A control word for this channel with access = 00 copies the current count into a latch, whatever its mode and bcd bits hold. It raises no error and does not disturb the countdown.
- R4: A latch command that arrives while an earlier snapshot is still unread is ignored, and the first snapshot is kept.
- R5: Data reads return the low byte and then the high byte. A pending snapshot is read in preference to the live count. It is released after its high byte is read, and later reads return the live count.
- R6: The first data write replaces the low byte of the count and halts any countdown. The second write replaces the high byte and starts counting from the full 16-bit value.
- R7: Mode 0 (control 0x30): the output is low after the count is loaded. It goes high on the tick that takes the count from 1 to 0. It then stays high, and counting stops.
- R8: Mode 2 (control 0x34) with start value N: the output is high after loading. It is low only while the count equals 1, and the count then reloads N on the next tick. The period is N ticks.
- R9: Mode 3 (control 0x36) with start value N: the output is high for ceil(N/2) ticks and low for floor(N/2) ticks of every N-tick period.
- R10: The count changes only on a cycle with `tick_en` high while a countdown is running, or on a data write.
- R11: A valid mode-setting control word (access = 11) resets both byte pointers to the low byte and halts the countdown. It sets the output low for mode 0 and high for modes 2 and 3.
- R12: After reset the count is 0, the mode is 0, the output is low, `cfg_err` is low, no snapshot is pending and both pointers are at the low byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_data | input | 8 | Control byte |
| dat_wr | input | 1 | Data byte write strobe |
| dat_wdata | input | 8 | Data byte written |
| dat_rd | input | 1 | Data byte read strobe; advances the read pointer |
| tick_en | input | 1 | Count enable at the timer rate |
| dat_rdata | output | 8 | Byte at the current read pointer |
| timer_out | output | 1 | Channel output |
| cfg_err | output | 1 | One-cycle pulse for an unsupported control word |

## Verification
The bench first lets a countdown run partway and then sends a bare low-byte write. A design that keeps counting, or restarts without the high byte, shows a moving count when read back. Two latch commands are sent some ticks apart before any readout; a design that overwrites the snapshot returns the later value. Reading past the snapshot's high byte shows whether the latch is released, since a stuck latch returns stale bytes. Bad control words are sent in the middle of a countdown, and words for another channel are mixed in. A decoder that acts on them stops or restarts the count, or raises a false error. The rate and square-wave outputs are compared tick by tick against the N-tick pattern, which catches off-by-one reloads and an uneven split of the high and low halves.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int BYTE_W  = 8;
    localparam int COUNT_W = 16;

    typedef enum logic [2:0] {
        MODE_TC   = 3'd0,
        MODE_RATE = 3'd2,
        MODE_SQR  = 3'd3
    } tmr_mode_e;

    typedef struct packed {
        logic      latch;
        logic      setup;
        logic      bad;
        tmr_mode_e mode;
    } ctl_cmd_t;

    // Effective period of a start value: zero stands for a full wrap.
    function automatic logic [COUNT_W:0] span_of(input logic [COUNT_W-1:0] v);
        return (v == '0) ? {1'b1, {COUNT_W{1'b0}}} : {1'b0, v};
    endfunction

    function automatic logic mode_ok(input logic [2:0] m);
        return (m == 3'd0) || (m == 3'd2) || (m == 3'd3);
    endfunction

endpackage

// File: rtl/pit_ctl_decode.sv
module pit_ctl_decode
    import pit_pkg::*;
#(
    parameter logic [1:0] CHAN_SEL = 2'd0
) (
    input  logic                ctl_wr,
    input  logic [BYTE_W-1:0]   ctl_data,
    output ctl_cmd_t            cmd
);
    localparam logic [1:0] SEL_READBACK = 2'b11;
    localparam logic [1:0] ACC_LATCH    = 2'b00;
    localparam logic [1:0] ACC_LOHI     = 2'b11;

    logic [1:0] sel_f;
    logic [1:0] acc_f;
    logic [2:0] mode_f;
    logic       bcd_f;

    assign sel_f  = ctl_data[7:6];
    assign acc_f  = ctl_data[5:4];
    assign mode_f = ctl_data[3:1];
    assign bcd_f  = ctl_data[0];

    always_comb begin
        cmd       = '0;
        cmd.mode  = MODE_TC;
        if (ctl_wr) begin
            if (sel_f == SEL_READBACK) begin
                cmd.bad = 1'b1;
            end else if (sel_f == CHAN_SEL) begin
                if (acc_f == ACC_LATCH) begin
                    cmd.latch = 1'b1;
                end else if (acc_f != ACC_LOHI || bcd_f || !mode_ok(mode_f)) begin
                    cmd.bad = 1'b1;
                end else begin
                    cmd.setup = 1'b1;
                    cmd.mode  = tmr_mode_e'(mode_f);
                end
            end
        end
    end

    // R2 / R3: a command is at most one of latch, setup, error.
    always_comb begin
        assert_one_kind_R2: assert ($onehot0({cmd.latch, cmd.setup, cmd.bad}));
    end

endmodule

// File: rtl/pit_byte_port.sv
module pit_byte_port
    import pit_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 setup,
    input  logic                 latch_req,
    input  logic [COUNT_W-1:0]   live_count,
    input  logic                 dat_wr,
    input  logic                 dat_rd,
    output logic                 load_lo,
    output logic                 load_hi,
    output logic [BYTE_W-1:0]    rdata
);
    logic                wr_hi;
    logic                rd_hi;
    logic                held;
    logic [COUNT_W-1:0]  snap;
    logic [COUNT_W-1:0]  src;
    logic                release_now;

    assign load_lo     = dat_wr && !wr_hi && !setup;
    assign load_hi     = dat_wr &&  wr_hi && !setup;
    assign release_now = dat_rd && rd_hi && held;
    assign src         = held ? snap : live_count;
    assign rdata       = rd_hi ? src[COUNT_W-1:BYTE_W] : src[BYTE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_hi <= 1'b0;
            rd_hi <= 1'b0;
            held  <= 1'b0;
            snap  <= '0;
        end else begin
            if (setup) begin
                wr_hi <= 1'b0;
                rd_hi <= 1'b0;
            end else begin
                if (dat_wr) wr_hi <= !wr_hi;
                if (dat_rd) rd_hi <= !rd_hi;
            end
            if (release_now) begin
                held <= 1'b0;
            end else if (latch_req && !held) begin
                held <= 1'b1;
                snap <= live_count;
            end
        end
    end

    // R4: a pending snapshot is never replaced.
    assert_snap_kept_R4: assert property (@(posedge clk) disable iff (rst)
        held && !release_now |=> held && $stable(snap));

    // R11: a setup word returns both pointers to the low byte.
    assert_ptr_reset_R11: assert property (@(posedge clk) disable iff (rst)
        setup |=> !wr_hi && !rd_hi);

endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter
    import pit_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 setup,
    input  tmr_mode_e            setup_mode,
    input  logic                 load_lo,
    input  logic                 load_hi,
    input  logic [BYTE_W-1:0]    wbyte,
    output logic [COUNT_W-1:0]   count,
    output logic                 out
);
    tmr_mode_e           mode_q;
    logic [COUNT_W-1:0]  reload;
    logic                running;
    logic                at_one;
    logic [COUNT_W-1:0]  nxt;
    logic                nxt_out;

    assign at_one = (count == {{(COUNT_W-1){1'b0}}, 1'b1});

    always_comb begin
        nxt     = count - 1'b1;
        nxt_out = out;
        unique case (mode_q)
            MODE_TC: begin
                if (at_one) nxt_out = 1'b1;
            end
            MODE_RATE: begin
                if (at_one) nxt = reload;
                nxt_out = (nxt != {{(COUNT_W-1){1'b0}}, 1'b1});
            end
            MODE_SQR: begin
                if (at_one) nxt = reload;
                nxt_out = span_of(nxt) > (span_of(reload) >> 1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_TC;
            reload  <= '0;
            count   <= '0;
            running <= 1'b0;
            out     <= 1'b0;
        end else if (setup) begin
            mode_q  <= setup_mode;
            running <= 1'b0;
            out     <= (setup_mode != MODE_TC);
        end else if (load_lo) begin
            count[BYTE_W-1:0]  <= wbyte;
            reload[BYTE_W-1:0] <= wbyte;
            running            <= 1'b0;
        end else if (load_hi) begin
            count[COUNT_W-1:BYTE_W]  <= wbyte;
            reload[COUNT_W-1:BYTE_W] <= wbyte;
            running                  <= 1'b1;
            out                      <= (mode_q != MODE_TC);
        end else if (tick && running) begin
            count <= nxt;
            out   <= nxt_out;
            if (mode_q == MODE_TC && at_one) running <= 1'b0;
        end
    end

    // R10: without a tick or a write the count holds.
    assert_tick_gate_R10: assert property (@(posedge clk) disable iff (rst)
        !tick && !load_lo && !load_hi |=> $stable(count));

    // R6: a low-byte write halts the countdown.
    assert_lo_halts_R6: assert property (@(posedge clk) disable iff (rst)
        load_lo && !setup |=> !running);

    // R7: once high in mode 0, the output stays high until reloaded.
    assert_tc_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        mode_q == MODE_TC && out && !load_hi && !setup |=> out);

    // R8: the rate generator's low phase lasts one tick.
    assert_rate_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        mode_q == MODE_RATE && running && !out && tick && !setup && !load_lo && !load_hi
        |=> out);

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter logic [1:0] CHAN_SEL = 2'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_wr,
    input  logic [7:0]  ctl_data,
    input  logic        dat_wr,
    input  logic [7:0]  dat_wdata,
    input  logic        dat_rd,
    input  logic        tick_en,
    output logic [7:0]  dat_rdata,
    output logic        timer_out,
    output logic        cfg_err
);
    ctl_cmd_t            cmd;
    logic                load_lo;
    logic                load_hi;
    logic [COUNT_W-1:0]  count;
    logic                err_q;

    pit_ctl_decode #(.CHAN_SEL(CHAN_SEL)) u_dec (
        .ctl_wr   (ctl_wr),
        .ctl_data (ctl_data),
        .cmd      (cmd)
    );

    pit_byte_port u_port (
        .clk        (clk),
        .rst        (rst),
        .setup      (cmd.setup),
        .latch_req  (cmd.latch),
        .live_count (count),
        .dat_wr     (dat_wr),
        .dat_rd     (dat_rd),
        .load_lo    (load_lo),
        .load_hi    (load_hi),
        .rdata      (dat_rdata)
    );

    pit_down_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_en),
        .setup      (cmd.setup),
        .setup_mode (cmd.mode),
        .load_lo    (load_lo),
        .load_hi    (load_hi),
        .wbyte      (dat_wdata),
        .count      (count),
        .out        (timer_out)
    );

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= cmd.bad;
    end

    assign cfg_err = err_q;

    // R2: a read-back select always reports an error next cycle.
    assert_readback_err_R2: assert property (@(posedge clk) disable iff (rst)
        ctl_wr && ctl_data[7:6] == 2'b11 |=> cfg_err);

    // R1: a word for another channel never reports an error.
    assert_other_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        ctl_wr && ctl_data[7:6] != 2'b11 && ctl_data[7:6] != CHAN_SEL |=> !cfg_err);

endmodule

// File: tb/pit_channel_test.sv
module pit_channel_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_data = '0;
    logic       dat_wr = 1'b0;
    logic [7:0] dat_wdata = '0;
    logic       dat_rd = 1'b0;
    logic       tick_en = 1'b0;
    logic [7:0] dat_rdata;
    logic       timer_out;
    logic       cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = !clk;

    pit_channel uut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd),
        .tick_en(tick_en), .dat_rdata(dat_rdata), .timer_out(timer_out),
        .cfg_err(cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic ctl_w(input logic [7:0] b);
        ctl_wr = 1'b1; ctl_data = b;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic dat_w(input logic [7:0] b);
        dat_wr = 1'b1; dat_wdata = b;
        @(negedge clk);
        dat_wr = 1'b0;
    endtask

    task automatic dat_r(output logic [7:0] v);
        v = dat_rdata;
        dat_rd = 1'b1;
        @(negedge clk);
        dat_rd = 1'b0;
    endtask

    task automatic read16(output int v);
        logic [7:0] lo, hi;
        dat_r(lo);
        dat_r(hi);
        v = {hi, lo};
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R12 out", timer_out, 0);
        check("R12 err", cfg_err, 0);
        check("R12 count low", dat_rdata, 0);
    endtask

    task automatic t_mode0;
        int v;
        ctl_w(8'h30);
        dat_w(8'h05);
        dat_w(8'h00);
        check("R7 low after load", timer_out, 0);
        ticks(2);
        read16(v);
        check("R5 live count", v, 3);
        idle(10);
        read16(v);
        check("R10 idle holds count", v, 3);
        ticks(2);
        check("R7 still low at count 1", timer_out, 0);
        ticks(1);
        check("R7 high at terminal", timer_out, 1);
        ticks(3);
        check("R7 stays high", timer_out, 1);
        read16(v);
        check("R7 count stopped at 0", v, 0);
    endtask

    task automatic t_low_halts;
        int v;
        ctl_w(8'h30);
        dat_w(8'h0A);
        dat_w(8'h00);
        ticks(3);
        dat_w(8'h20);
        ticks(5);
        read16(v);
        check("R6 low write halts", v, 16'h0020);
        dat_w(8'h01);
        check("R6 out low on arm", timer_out, 0);
        ticks(1);
        read16(v);
        check("R6 high write starts", v, 16'h011F);
    endtask

    task automatic t_latch;
        int v;
        ctl_w(8'h30);
        dat_w(8'h10);
        dat_w(8'h00);
        ticks(2);
        ctl_w(8'h0F);
        check("R3 latch no err", cfg_err, 0);
        ticks(3);
        ctl_w(8'h00);
        ticks(1);
        read16(v);
        check("R4 first snapshot kept", v, 14);
        read16(v);
        check("R5 latch released", v, 10);
        read16(v);
        check("R3 countdown undisturbed", v, 10);
    endtask

    task automatic t_other_chan;
        int v;
        ctl_w(8'h30);
        dat_w(8'h08);
        dat_w(8'h00);
        ctl_w(8'h70);
        check("R1 other channel no err", cfg_err, 0);
        ticks(2);
        read16(v);
        check("R1 other setup ignored", v, 6);
        ctl_w(8'h40);
        ticks(1);
        read16(v);
        check("R1 other latch ignored", v, 5);
    endtask

    task automatic t_errors;
        int v;
        logic [7:0] bad [5] = '{8'hC0, 8'h10, 8'h32, 8'h38, 8'h31};
        ctl_w(8'h30);
        dat_w(8'h09);
        dat_w(8'h00);
        for (int i = 0; i < 5; i++) begin
            ctl_w(bad[i]);
            check($sformatf("R2 err for 0x%0h", bad[i]), cfg_err, 1);
            idle(1);
            check("R2 err one cycle", cfg_err, 0);
        end
        check("R2 out unchanged", timer_out, 0);
        ticks(2);
        read16(v);
        check("R2 count unaffected", v, 7);
    endtask

    task automatic t_mode2;
        int lows = 0;
        ctl_w(8'h34);
        dat_w(8'h03);
        dat_w(8'h00);
        check("R8 high after load", timer_out, 1);
        for (int i = 1; i <= 9; i++) begin
            ticks(1);
            check($sformatf("R8 tick %0d", i), timer_out, (i % 3 == 2) ? 0 : 1);
            if (!timer_out) lows++;
        end
        check("R8 low ticks", lows, 3);
    endtask

    task automatic t_mode3;
        int highs = 0;
        ctl_w(8'h36);
        dat_w(8'h05);
        dat_w(8'h00);
        check("R9 high after load", timer_out, 1);
        for (int i = 1; i <= 10; i++) begin
            ticks(1);
            check($sformatf("R9 tick %0d", i), timer_out,
                  (i % 5 == 3 || i % 5 == 4) ? 0 : 1);
            if (timer_out) highs++;
        end
        check("R9 high ticks", highs, 6);
    endtask

    task automatic t_setup;
        int v;
        logic [7:0] b;
        ctl_w(8'h30);
        dat_w(8'h22);
        ctl_w(8'h30);
        dat_w(8'h03);
        dat_w(8'h00);
        ticks(3);
        check("R11 write pointer reset", timer_out, 1);
        ctl_w(8'h30);
        dat_w(8'h10);
        dat_w(8'h00);
        ticks(1);
        dat_r(b);
        ctl_w(8'h36);
        check("R11 mode3 out high", timer_out, 1);
        ticks(3);
        read16(v);
        check("R11 read pointer reset and halt", v, 15);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_mode0();
        t_low_halts();
        t_latch();
        t_other_chan();
        t_errors();
        t_mode2();
        t_mode3();
        t_setup();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule